// File: doc/BRIEF.md
# Bit-Interleaved Parity Striping Unit

This block joins a host byte stream to an array of data channels that share one dedicated parity channel. On the write side it takes host bytes one at a time and places them round-robin on the data channels. Byte k of a stripe goes to channel k. Once every data lane of a stripe holds a byte, the block presents the whole stripe in a single cycle, together with a parity byte that is the bitwise XOR of the data lanes. All channels, parity included, must accept a stripe in the same cycle. If the host marks the end of a transfer part-way through a stripe, the lanes still empty are sent as zeros.

On the read side the block takes one complete stripe from all channels at once, stores it, and returns the bytes to the host in channel order. In normal mode it checks the stored parity against the data, and any mismatch sets a flag that stays set until reset. In degraded mode one data channel is marked as failed. The block then ignores that channel's input and rebuilds its byte from the parity byte and the surviving lanes, so reads go on without stalling. No parity check is possible in that mode, so the flag is left as it is. The failure selection is sampled only when a stripe is taken in.

Both sides use valid/ready handshakes. A single stripe register on each side is enough for full throughput, because a new host byte or a new channel stripe can enter in the same cycle that the previous contents leave.

Top module: `parity_stripe_unit`

## Requirements
- R1: While reset is held low and right after it, `hostWrReady` and `chRdReady` are 1, and `chWrValid`, `hostRdValid` and `parityErr` are 0.
- R2: The k-th host byte accepted in a stripe (k counted from 0) appears on lane k of `chWrData`, which is bits [8k+7:8k]. `chWrValid` rises in the cycle after the NUM_CH-th byte is accepted.
- R3: Whenever `chWrValid` is 1, `chWrPar` equals the bitwise XOR of all NUM_CH lanes of `chWrData`.
- R4: A byte accepted with `hostWrLast`=1 closes the stripe at its position. The lanes above it are driven as 0, and the parity covers those zero lanes.
- R5: A write stripe is handed over only in a cycle where every bit of `chWrReady` is 1 (bit NUM_CH is the parity channel). Until then `chWrData` and `chWrPar` hold steady and `hostWrReady` is 0.
- R6: In the cycle a pending write stripe is handed over, `hostWrReady` is 1, so the first byte of the next stripe is taken with no idle cycle.
- R7: A read stripe is taken when `chRdValid` and `chRdReady` are both 1. From the next cycle its bytes go out on `hostRdData` in order, lane 0 to lane NUM_CH-1, one byte per `hostRdValid`/`hostRdReady` handshake. Each byte is held until it is accepted.
- R8: `chRdReady` is 0 while stored read bytes remain. The only exception is the cycle in which the last stored byte is accepted, where `chRdReady` is 1 so the next stripe can be loaded in that same cycle.
- R9: In normal mode (`degEn`=0), a stripe taken in with `chRdPar` different from the XOR of its lanes sets `parityErr` from the next cycle. `parityErr` then stays 1 until reset.
- R10: In degraded mode (`degEn`=1, `failedCh` < NUM_CH), the lane given by `failedCh` is ignored and replaced by `chRdPar` XOR the other lanes. `parityErr` is not changed by such a stripe.
- R11: `degEn` and `failedCh` matter only in the cycle a read stripe is taken. Changing them while that stripe is being returned does not alter the bytes that come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrValid | input | 1 | Host write byte valid |
| hostWrReady | output | 1 | Block can accept a host write byte |
| hostWrData | input | 8 | Host write byte |
| hostWrLast | input | 1 | Byte ends the transfer; the open stripe is padded and closed |
| chWrValid | output | 1 | Write stripe valid toward all channels |
| chWrReady | input | NUM_CH+1 | Per-channel ready; bit NUM_CH is the parity channel |
| chWrData | output | 8*NUM_CH | Data lanes; lane k at bits [8k+7:8k] |
| chWrPar | output | 8 | Parity byte for the write stripe |
| chRdValid | input | 1 | Read stripe valid from all channels |
| chRdReady | output | 1 | Block can take a read stripe |
| chRdData | input | 8*NUM_CH | Read data lanes; lane k at bits [8k+7:8k] |
| chRdPar | input | 8 | Read parity byte |
| degEn | input | 1 | Degraded mode enable, sampled when a read stripe is taken |
| failedCh | input | clog2(NUM_CH) | Index of the failed data channel |
| hostRdValid | output | 1 | Host read byte valid |
| hostRdReady | input | 1 | Host accepts the read byte |
| hostRdData | output | 8 | Host read byte |
| parityErr | output | 1 | Sticky read parity error flag |

## Verification
On each side, two events can fall in the same cycle: a stored stripe leaves, and new data arrives. On the write side, a full stripe is handed to the channels while the host presents the first byte of the next stripe. On the read side, the host takes the last stored byte while the channels offer the next stripe. One phase of the bench holds every channel ready, the host write valid and the host read ready continuously high, which forces both overlaps again and again. In the other phases, ready and valid are randomized per bit. A behavioural queue model predicts every output on every cycle, so a lost byte, a dropped stripe or an extra bubble in an overlap cycle is seen as a mismatch in data, a ready or a valid.

// File: rtl/pstripe_pkg.sv
package pstripe_pkg;
  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic wrTake;   // store the host byte into the current write slot
    logic wrFlush;  // write stripe handed over, clear buffer to zero
    logic rdTake;   // capture a read stripe (rebuilt if degraded)
  } stripe_strobe_t;
endpackage

// File: rtl/pstripe_lane_xor.sv
module pstripe_lane_xor #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input  logic [NUM_CH*BYTE_W-1:0] lanes,
  output logic [BYTE_W-1:0]        folded
);
  always_comb begin
    folded = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      folded = folded ^ lanes[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/pstripe_ctrl.sv
module pstripe_ctrl
  import pstripe_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hostWrValid,
  input  logic             hostWrLast,
  output logic             hostWrReady,
  input  logic             chWrReadyAll,
  output logic             chWrValid,
  input  logic             chRdValid,
  output logic             chRdReady,
  input  logic             hostRdReady,
  output logic             hostRdValid,
  output stripe_strobe_t   strobe,
  output logic [IDX_W-1:0] wrSlot,
  output logic [IDX_W-1:0] rdSlot
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_CH - 1);

  logic             wrFull, rdFull;
  logic [IDX_W-1:0] wrCnt, rdCnt;
  logic             wrOut, wrIn, rdPop, rdPopLast, rdIn;

  // write side: collect bytes, hand over a stripe when all channels ready
  assign chWrValid   = wrFull;
  assign wrOut       = wrFull && chWrReadyAll;
  assign hostWrReady = !wrFull || wrOut;
  assign wrIn        = hostWrValid && hostWrReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrFull <= 1'b0;
      wrCnt  <= '0;
    end else begin
      if (wrOut) wrFull <= 1'b0;
      if (wrIn) begin
        if (hostWrLast || wrCnt == LAST_SLOT) begin
          wrFull <= 1'b1;
          wrCnt  <= '0;
        end else begin
          wrCnt <= wrCnt + 1'b1;
        end
      end
    end
  end

  // read side: load a stripe, then serialize lanes in order
  assign hostRdValid = rdFull;
  assign rdPop       = rdFull && hostRdReady;
  assign rdPopLast   = rdPop && (rdCnt == LAST_SLOT);
  assign chRdReady   = !rdFull || rdPopLast;
  assign rdIn        = chRdValid && chRdReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdFull <= 1'b0;
      rdCnt  <= '0;
    end else begin
      if (rdPopLast) begin
        rdFull <= 1'b0;
        rdCnt  <= '0;
      end else if (rdPop) begin
        rdCnt <= rdCnt + 1'b1;
      end
      if (rdIn) begin
        rdFull <= 1'b1;
        rdCnt  <= '0;
      end
    end
  end

  assign strobe.wrTake  = wrIn;
  assign strobe.wrFlush = wrOut;
  assign strobe.rdTake  = rdIn;
  assign wrSlot = wrCnt;
  assign rdSlot = rdCnt;
endmodule

// File: rtl/pstripe_dp.sv
module pstripe_dp
  import pstripe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LANES_W = NUM_CH * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stripe_strobe_t     strobe,
  input  logic [IDX_W-1:0]   wrSlot,
  input  logic [IDX_W-1:0]   rdSlot,
  input  logic [BYTE_W-1:0]  hostWrData,
  output logic [LANES_W-1:0] chWrData,
  output logic [BYTE_W-1:0]  chWrPar,
  input  logic [LANES_W-1:0] chRdData,
  input  logic [BYTE_W-1:0]  chRdPar,
  input  logic               degEn,
  input  logic [IDX_W-1:0]   failedCh,
  output logic [BYTE_W-1:0]  hostRdData,
  output logic               parityErr
);
  logic [LANES_W-1:0] wrBuf, wrNext, rdBuf, rdFixed;
  logic [BYTE_W-1:0]  rdFold, fixByte;
  logic               degNow;

  // write buffer: flush to zero gives padding for a short stripe
  always_comb begin
    wrNext = strobe.wrFlush ? '0 : wrBuf;
    if (strobe.wrTake) wrNext[int'(wrSlot)*BYTE_W +: BYTE_W] = hostWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wrBuf <= '0;
    else        wrBuf <= wrNext;
  end

  pstripe_lane_xor #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_wrFold (
    .lanes(wrBuf), .folded(chWrPar)
  );
  assign chWrData = wrBuf;

  // read path: fold incoming lanes once, used for both check and rebuild
  pstripe_lane_xor #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_rdFold (
    .lanes(chRdData), .folded(rdFold)
  );

  assign degNow  = degEn && (int'(failedCh) < NUM_CH);
  assign fixByte = chRdPar ^ rdFold ^ chRdData[int'(failedCh)*BYTE_W +: BYTE_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    assign rdFixed[i*BYTE_W +: BYTE_W] =
      (degNow && failedCh == IDX_W'(i)) ? fixByte : chRdData[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdBuf     <= '0;
      parityErr <= 1'b0;
    end else if (strobe.rdTake) begin
      rdBuf <= rdFixed;
      if (!degNow && rdFold != chRdPar) parityErr <= 1'b1;
    end
  end

  assign hostRdData = rdBuf[int'(rdSlot)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/parity_stripe_unit.sv
module parity_stripe_unit
  import pstripe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LANES_W = NUM_CH * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hostWrValid,
  output logic               hostWrReady,
  input  logic [BYTE_W-1:0]  hostWrData,
  input  logic               hostWrLast,
  output logic               chWrValid,
  input  logic [NUM_CH:0]    chWrReady,
  output logic [LANES_W-1:0] chWrData,
  output logic [BYTE_W-1:0]  chWrPar,
  input  logic               chRdValid,
  output logic               chRdReady,
  input  logic [LANES_W-1:0] chRdData,
  input  logic [BYTE_W-1:0]  chRdPar,
  input  logic               degEn,
  input  logic [IDX_W-1:0]   failedCh,
  output logic               hostRdValid,
  input  logic               hostRdReady,
  output logic [BYTE_W-1:0]  hostRdData,
  output logic               parityErr
);
  stripe_strobe_t   strobe;
  logic [IDX_W-1:0] wrSlot, rdSlot;

  pstripe_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hostWrValid(hostWrValid), .hostWrLast(hostWrLast), .hostWrReady(hostWrReady),
    .chWrReadyAll(&chWrReady), .chWrValid(chWrValid),
    .chRdValid(chRdValid), .chRdReady(chRdReady),
    .hostRdReady(hostRdReady), .hostRdValid(hostRdValid),
    .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot)
  );

  pstripe_dp #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .hostWrData(hostWrData), .chWrData(chWrData), .chWrPar(chWrPar),
    .chRdData(chRdData), .chRdPar(chRdPar), .degEn(degEn), .failedCh(failedCh),
    .hostRdData(hostRdData), .parityErr(parityErr)
  );
endmodule

// File: rtl/parity_stripe_unit_chk.sv
module parity_stripe_unit_chk #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LANES_W = NUM_CH * BYTE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hostWrReady,
  input logic               chWrValid,
  input logic [NUM_CH:0]    chWrReady,
  input logic [LANES_W-1:0] chWrData,
  input logic [BYTE_W-1:0]  chWrPar,
  input logic               chRdValid,
  input logic               chRdReady,
  input logic               degEn,
  input logic [IDX_W-1:0]   failedCh,
  input logic               hostRdValid,
  input logic               hostRdReady,
  input logic [BYTE_W-1:0]  hostRdData,
  input logic               parityErr
);
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chWrValid && !(&chWrReady)) |=> (chWrValid && $stable(chWrData) && $stable(chWrPar)));

  a_r5_wr_block: assert property (@(posedge clk) disable iff (!rst_n)
    (chWrValid && !(&chWrReady)) |-> !hostWrReady);

  a_r6_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (chWrValid && (&chWrReady)) |-> hostWrReady);

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRdValid && !hostRdReady) |=> (hostRdValid && $stable(hostRdData)));

  a_r8_rd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRdValid && !hostRdReady) |-> !chRdReady);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    parityErr |=> parityErr);

  a_r10_deg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chRdValid && chRdReady && degEn && (int'(failedCh) < NUM_CH) && !parityErr) |=> !parityErr);
endmodule

bind parity_stripe_unit parity_stripe_unit_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hostWrReady(hostWrReady), .chWrValid(chWrValid),
  .chWrReady(chWrReady), .chWrData(chWrData), .chWrPar(chWrPar),
  .chRdValid(chRdValid), .chRdReady(chRdReady), .degEn(degEn), .failedCh(failedCh),
  .hostRdValid(hostRdValid), .hostRdReady(hostRdReady), .hostRdData(hostRdData),
  .parityErr(parityErr)
);

// File: tb/parity_stripe_unit_bench.sv
module parity_stripe_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWrValid = 1'b0, hostWrLast = 1'b0, hostWrReady;
  logic [W-1:0] hostWrData = '0;
  logic chWrValid;
  logic [N:0] chWrReady = '0;
  logic [N*W-1:0] chWrData;
  logic [W-1:0] chWrPar;
  logic chRdValid = 1'b0, chRdReady;
  logic [N*W-1:0] chRdData = '0;
  logic [W-1:0] chRdPar = '0;
  logic degEn = 1'b0;
  logic [IW-1:0] failedCh = '0;
  logic hostRdValid, hostRdReady = 1'b0;
  logic [W-1:0] hostRdData;
  logic parityErr;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit finished = 0;
  int phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_stripe_unit #(.NUM_CH(N), .BYTE_W(W)) u_parity_stripe_unit (.*);

  // reference model state
  logic [W-1:0]   wrCur[$];
  logic [N*W-1:0] wrPend[$];
  logic [W-1:0]   rdQ[$];
  bit             errExp = 0;

  function automatic logic [W-1:0] fold(input logic [N*W-1:0] v);
    logic [W-1:0] a = '0;
    for (int k = 0; k < N; k++) a ^= v[k*W +: W];
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on each clock edge from the sampled inputs
  always @(posedge clk) begin
    bit wOut, hwr, pop, crr;
    logic [N*W-1:0] v;
    logic [W-1:0] x, b;
    if (!rst_n) begin
      wrCur.delete(); wrPend.delete(); rdQ.delete(); errExp = 0;
    end else begin
      wOut = (wrPend.size() != 0) && (&chWrReady);
      hwr  = (wrPend.size() == 0) || wOut;
      if (wOut) void'(wrPend.pop_front());
      if (hostWrValid && hwr) begin
        wrCur.push_back(hostWrData);
        if (hostWrLast || wrCur.size() == N) begin
          v = '0;
          for (int k = 0; k < wrCur.size(); k++) v[k*W +: W] = wrCur[k];
          wrPend.push_back(v);
          wrCur.delete();
        end
      end
      pop = (rdQ.size() != 0) && hostRdReady;
      crr = (rdQ.size() == 0) || (rdQ.size() == 1 && hostRdReady);
      if (pop) void'(rdQ.pop_front());
      if (chRdValid && crr) begin
        x = fold(chRdData);
        if (!degEn && x != chRdPar) errExp = 1;
        for (int k = 0; k < N; k++) begin
          b = chRdData[k*W +: W];
          if (degEn && k == int'(failedCh)) begin
            b = chRdPar;
            for (int j = 0; j < N; j++) if (j != k) b ^= chRdData[j*W +: W];
          end
          rdQ.push_back(b);
        end
      end
    end
  end

  // compare every cycle, a quarter period after inputs change
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (running && rst_n) begin
      chk(chWrValid == (wrPend.size() != 0), "R2 chWrValid", chWrValid, wrPend.size() != 0);
      if (wrPend.size() != 0) begin
        chk(chWrData == wrPend[0], "R2/R4 chWrData", chWrData, wrPend[0]);
        chk(chWrPar == fold(wrPend[0]), "R3 chWrPar", chWrPar, fold(wrPend[0]));
      end
      chk(hostWrReady == ((wrPend.size() == 0) || (&chWrReady)), "R5/R6 hostWrReady",
          hostWrReady, (wrPend.size() == 0) || (&chWrReady));
      chk(hostRdValid == (rdQ.size() != 0), "R7 hostRdValid", hostRdValid, rdQ.size() != 0);
      if (rdQ.size() != 0)
        chk(hostRdData == rdQ[0], "R7/R10/R11 hostRdData", hostRdData, rdQ[0]);
      chk(chRdReady == ((rdQ.size() == 0) || (rdQ.size() == 1 && hostRdReady)), "R8 chRdReady",
          chRdReady, (rdQ.size() == 0) || (rdQ.size() == 1 && hostRdReady));
      chk(parityErr == errExp, "R9/R10 parityErr", parityErr, errExp);
    end
  end

  task automatic drive();
    logic [N*W-1:0] lanes;
    logic [IW-1:0] fc;
    bool_dummy: begin end
    hostWrValid = (phase == 2) ? 1'b1 : (($urandom % 100) < 70);
    hostWrData  = W'($urandom);
    hostWrLast  = (($urandom % 8) == 0);
    for (int k = 0; k <= N; k++) chWrReady[k] = (phase == 2) ? 1'b1 : (($urandom % 4) != 0);
    hostRdReady = (phase == 2) ? 1'b1 : (($urandom % 100) < 65);
    chRdValid   = (phase == 2) ? 1'b1 : (($urandom % 100) < 60);
    lanes = '0;
    for (int k = 0; k < N; k++) lanes[k*W +: W] = W'($urandom);
    chRdPar = fold(lanes);
    if (phase == 4 && ($urandom % 3) == 0) chRdPar ^= W'(1 << ($urandom % W));
    fc = IW'($urandom % N);
    degEn = (phase == 3);
    failedCh = fc;
    if (phase == 3) lanes[int'(fc)*W +: W] = W'($urandom);  // failed channel carries junk
    chRdData = lanes;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    // R1 reset state
    chk(hostWrReady == 1'b1, "R1 hostWrReady", hostWrReady, 1);
    chk(chWrValid == 1'b0, "R1 chWrValid", chWrValid, 0);
    chk(chRdReady == 1'b1, "R1 chRdReady", chRdReady, 1);
    chk(hostRdValid == 1'b0, "R1 hostRdValid", hostRdValid, 0);
    chk(parityErr == 1'b0, "R1 parityErr", parityErr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    phase = 1; repeat (3000) begin @(negedge clk); drive(); end  // normal, random handshakes
    phase = 2; repeat (1000) begin @(negedge clk); drive(); end  // full-rate overlap (R6, R8)
    phase = 3; repeat (3000) begin @(negedge clk); drive(); end  // degraded, R10/R11
    @(negedge clk); #(CLK_PERIOD/4);
    chk(parityErr == 1'b0, "R10 flag untouched in degraded", parityErr, 0);
    phase = 4; repeat (2000) begin @(negedge clk); drive(); end  // corrupted parity, R9
    @(negedge clk); #(CLK_PERIOD/4);
    chk(parityErr == 1'b1, "R9 sticky flag set", parityErr, 1);
    running = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule